// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver

This block receives 8-bit frames over a clocked serial line. Bits enter a shift register on each rising edge of the serial clock, least significant bit first. The serial clock is either generated inside the block, with a fixed divider, and driven out on `sck_o`, or taken from an external pin. The external pin passes through a two-flop synchronizer, and its edges are detected in the system clock domain. When the eighth bit arrives, the assembled byte moves into a holding data register and a receive-full flag is set.

If a frame completes while the holding register is still full, the block flags an overrun. It discards the new byte and keeps the old byte, with its full flag still set. All further reception then stops until software has cleared both the overrun flag and the full flag. A small two-address register port reads the held byte and the status flags. Software clears a flag by writing 0 to its bit. Two level interrupt outputs, one for receive-complete and one for receive-error, are gated by an interrupt-enable input.

Top module: `sync_serial_rx`

## Requirements
- R1: Serial bits are sampled on rising serial-clock edges. The first bit sampled becomes bit 0 of the received byte, and the eighth becomes bit 7.
- R2: When a frame ends with the full flag clear, the byte is loaded into the data register (address 0) and the full flag (status address 1, bit 0) is 1 from the next cycle.
- R3: When a frame ends with the full flag set, the overrun flag (status bit 1) becomes 1, the data register keeps its old byte, and the full flag stays 1.
- R4: `rxi_o` is high while the full flag is 1 and `ie_i` is 1. `eri_o` is high while the overrun flag is 1 and `ie_i` is 1. With `ie_i` low, both outputs are low.
- R5: From an overrun until both the overrun flag and the full flag read 0, serial clock edges are ignored and no frame is accepted. Clearing only the overrun flag does not resume reception.
- R6: A status write clears each flag whose bit is written 0 (bit 0 full, bit 1 overrun). A written 1 leaves the flag unchanged. Status bits 2 (framing) and 3 (parity) always read 0. A read alters nothing.
- R7: With `ext_clk_sel_i`=1, a rising edge on `sck_ext_i` takes effect at the third system clock edge after it, because of two synchronizer flops and one edge register. With `ext_clk_sel_i`=0, an internal clock idling high with a half period of DIV_HALF system cycles shifts the data and appears on `sck_o`.
- R8: Deasserting `rx_en_i` discards any partial frame and resets the bit count. While `rx_en_i` is low, `sck_o` stays high.
- R9: If a status write clears the full flag in the same cycle that a frame ends, the new byte is loaded, the full flag stays 1, and no overrun is raised.
- R10: After reset, the data register is 0, all flags are 0, `sck_o` is 1 and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receive enable |
| ie_i | input | 1 | Receive interrupt enable |
| ext_clk_sel_i | input | 1 | 1 selects external serial clock, 0 selects internal clock |
| sck_ext_i | input | 1 | External serial clock pin |
| sdata_i | input | 1 | Serial data input |
| sck_o | output | 1 | Internal serial clock output, idles high |
| reg_addr_i | input | 1 | Register select: 0 data, 1 status |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| rxi_o | output | 1 | Receive-complete interrupt request |
| eri_o | output | 1 | Receive-error interrupt request |

## Verification
Frame completion and a software clear of the full flag can land on the same system clock edge, and this decides between a clean load and an overrun. The bench runs the external serial clock, so it knows the exact edge at which the eighth bit completes: the third system edge after the pin rises. It asserts the status write in the cycle just before that edge. The result passes only if the new byte is held, the full flag remains 1 and the overrun flag stays 0.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_FER  = 2;
  localparam int ST_PER  = 3;
endpackage

// File: rtl/srx_clk_gen.sv
module srx_clk_gen #(
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ext_sel_i,
  input  logic sck_ext_i,
  input  logic sdata_i,
  output logic sck_o,
  output logic rise_o,
  output logic sdata_o
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DIV_HALF - 1);

  logic [SYNC_STAGES-1:0] ck_sync_q, d_sync_q;
  logic ck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_sync_q[0] <= 1'b1;
      d_sync_q[0]  <= 1'b0;
    end else begin
      ck_sync_q[0] <= sck_ext_i;
      d_sync_q[0]  <= sdata_i;
    end
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ck_sync_q[i] <= 1'b1;
        d_sync_q[i]  <= 1'b0;
      end else begin
        ck_sync_q[i] <= ck_sync_q[i-1];
        d_sync_q[i]  <= d_sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ck_prev_q <= 1'b1;
    else         ck_prev_q <= ck_sync_q[SYNC_STAGES-1];
  end

  logic ext_rise;
  assign ext_rise = ck_sync_q[SYNC_STAGES-1] & ~ck_prev_q;

  // internal divider: idle high, toggles every DIV_HALF cycles while running
  logic [DW-1:0] div_q;
  logic sck_q, div_wrap;
  assign div_wrap = (div_q == DLAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i || ext_sel_i) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (div_wrap) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  logic int_rise;
  assign int_rise = run_i & ~ext_sel_i & div_wrap & ~sck_q;

  assign rise_o  = ext_sel_i ? ext_rise : int_rise;
  assign sck_o   = sck_q;
  assign sdata_o = d_sync_q[SYNC_STAGES-1];

  p_int_idle_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> sck_q);
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              rise_i,
  input  logic              sdata_i,
  output logic              frame_done_o,
  output logic [DATA_W-1:0] frame_data_o
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sreg_q;
  logic              take;

  assign take         = run_i & rise_i;
  assign frame_done_o = take & (cnt_q == LAST);
  // LSB first: new bit enters at the top and moves down
  assign frame_data_o = {sdata_i, sreg_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sreg_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (take) begin
      sreg_q <= frame_data_o;
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  p_idle_clears_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
  p_done_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
endmodule

// File: rtl/srx_flags.sv
module srx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              stat_wr_i,
  input  logic              wr_full_i,
  input  logic              wr_ovr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              lock_o
);
  logic [DATA_W-1:0] data_q;
  logic full_q, ovr_q, lock_q;
  logic full_kept, ovr_kept, set_ovr, load;
  logic full_n, ovr_n;

  // software clear applies before the frame-end decision
  assign full_kept = full_q & ~(stat_wr_i & ~wr_full_i);
  assign ovr_kept  = ovr_q  & ~(stat_wr_i & ~wr_ovr_i);
  assign load      = frame_done_i & ~full_kept;
  assign set_ovr   = frame_done_i &  full_kept;
  assign full_n    = full_kept | load;
  assign ovr_n     = ovr_kept  | set_ovr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (load) data_q <= frame_data_i;
      full_q <= full_n;
      ovr_q  <= ovr_n;
      lock_q <= set_ovr | (lock_q & (ovr_n | full_n));
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign lock_o = lock_q;

  p_load_sets_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_q != $past(data_q)) |-> full_q);
  p_ovr_holds_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> (data_q == $past(data_q)) && full_q);
  p_ovr_locks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> lock_q);
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              ie_i,
  input  logic              ext_clk_sel_i,
  input  logic              sck_ext_i,
  input  logic              sdata_i,
  output logic              sck_o,
  input  logic              reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              rxi_o,
  output logic              eri_o
);
  logic run, rise, sdata_s, frame_done, full, ovr, lock, stat_wr;
  logic [DATA_W-1:0] frame_data, data;
  logic unused_wdata;

  assign run          = rx_en_i & ~lock;
  assign stat_wr      = reg_wr_i & (reg_addr_i == ADDR_STAT);
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:2];

  srx_clk_gen #(.DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i, .rst_ni, .run_i(run), .ext_sel_i(ext_clk_sel_i),
    .sck_ext_i, .sdata_i, .sck_o, .rise_o(rise), .sdata_o(sdata_s)
  );

  srx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .run_i(run), .rise_i(rise), .sdata_i(sdata_s),
    .frame_done_o(frame_done), .frame_data_o(frame_data)
  );

  srx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i, .rst_ni, .frame_done_i(frame_done), .frame_data_i(frame_data),
    .stat_wr_i(stat_wr), .wr_full_i(reg_wdata_i[ST_FULL]),
    .wr_ovr_i(reg_wdata_i[ST_OVR]),
    .data_o(data), .full_o(full), .ovr_o(ovr), .lock_o(lock)
  );

  // framing and parity never set in synchronous mode
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_DATA) begin
      reg_rdata_o = data;
    end else begin
      reg_rdata_o[ST_FULL] = full;
      reg_rdata_o[ST_OVR]  = ovr;
      reg_rdata_o[ST_FER]  = 1'b0;
      reg_rdata_o[ST_PER]  = 1'b0;
    end
  end

  assign rxi_o = ie_i & full;
  assign eri_o = ie_i & ovr;

  p_locked_no_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> $stable(data));
endmodule

// File: tb/tb_sync_serial_rx.sv
module tb_sync_serial_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, ie = 1'b1, ext_sel = 1'b1, sck_ext = 1'b1, sdata = 1'b0;
  logic reg_addr = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00, rdata;
  logic sck_o, rxi, eri;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sync_serial_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .ie_i(ie),
    .ext_clk_sel_i(ext_sel), .sck_ext_i(sck_ext), .sdata_i(sdata),
    .sck_o(sck_o), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .rxi_o(rxi), .eri_o(eri)
  );

  // {ie, byte}
  localparam logic [8:0] VEC [6] = '{9'h1A5, 9'h03C, 9'h101, 9'h180, 9'h0FF, 9'h100};

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_stat(input logic [7:0] v);
    @(negedge clk); reg_addr = 1'b1; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = rdata;
  endtask

  // one external bit; optional status clear of full on the sampling edge
  task automatic ext_bit(input logic b, input logic clr, input logic probe);
    @(negedge clk); sdata = b; sck_ext = 1'b0;
    repeat (3) @(negedge clk);
    sck_ext = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (probe) begin reg_addr = 1'b1; #1 chk("R7 no effect before third edge", {7'd0, rdata[0]}, 8'd0); end
    if (clr) begin reg_addr = 1'b1; reg_wdata = 8'hFE; reg_wr = 1'b1; end
    @(negedge clk);
    reg_wr = 1'b0;
    if (probe) begin reg_addr = 1'b1; #1 chk("R7 loaded on third edge", {7'd0, rdata[0]}, 8'd1); end
    repeat (2) @(negedge clk);
  endtask

  task automatic send_ext(input logic [7:0] v, input logic clr_last, input logic probe);
    for (int i = 0; i < 8; i++) ext_bit(v[i], clr_last && i == 7, probe && i == 7);
  endtask

  task automatic send_int(input logic [7:0] v);
    @(negedge clk); rx_en = 1'b0; ext_sel = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin @(negedge sck_o); sdata = v[i]; end
    @(posedge sck_o);
    @(negedge clk); rx_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(1'b0, v); chk("R10 data reset", v, 8'h00);
    rd(1'b1, v); chk("R10 status reset (R6 fer/per zero)", v, 8'h00);
    chk("R10 sck_o idle", {7'd0, sck_o}, 8'd1);
    chk("R10 irqs low", {6'd0, rxi, eri}, 8'd0);

    @(negedge clk); rx_en = 1'b1;
    foreach (VEC[k]) begin
      ie = VEC[k][8];
      send_ext(VEC[k][7:0], 1'b0, 1'b0);
      rd(1'b0, v); chk("R1 byte order", v, VEC[k][7:0]);
      rd(1'b1, v); chk("R2 full set", v, 8'h01);
      chk("R4 rxi follows ie", {7'd0, rxi}, {7'd0, VEC[k][8]});
      wr_stat(8'hFE);
      rd(1'b1, v); chk("R6 full cleared by 0", v, 8'h00);
    end
    ie = 1'b1;

    // R7 external latency and R6 write-1 no effect
    send_ext(8'h3E, 1'b0, 1'b1);
    wr_stat(8'hFF);
    rd(1'b1, v); chk("R6 write 1 keeps flags", v, 8'h01);
    wr_stat(8'h00);

    // R3 overrun
    send_ext(8'h11, 1'b0, 1'b0);
    send_ext(8'h22, 1'b0, 1'b0);
    rd(1'b0, v); chk("R3 old data kept", v, 8'h11);
    rd(1'b1, v); chk("R3 overrun and full", v, 8'h03);
    chk("R4 eri with ie", {7'd0, eri}, 8'd1);
    @(negedge clk); ie = 1'b0; #1;
    chk("R4 irqs masked", {6'd0, rxi, eri}, 8'd0);
    ie = 1'b1;

    // R5 lock
    send_ext(8'h33, 1'b0, 1'b0);
    rd(1'b0, v); chk("R5 ignored while overrun", v, 8'h11);
    wr_stat(8'hFD);
    rd(1'b1, v); chk("R5 overrun cleared, full kept", v, 8'h01);
    send_ext(8'h44, 1'b0, 1'b0);
    rd(1'b0, v); chk("R5 still ignored with full", v, 8'h11);
    rd(1'b1, v); chk("R5 no new overrun", v, 8'h01);
    wr_stat(8'hFE);
    send_ext(8'h55, 1'b0, 1'b0);
    rd(1'b0, v); chk("R5 resumes after all clear", v, 8'h55);
    wr_stat(8'hFE);

    // R8 abort partial frame
    ext_bit(1'b1, 1'b0, 1'b0);
    ext_bit(1'b1, 1'b0, 1'b0);
    ext_bit(1'b0, 1'b0, 1'b0);
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk); rx_en = 1'b1;
    send_ext(8'h66, 1'b0, 1'b0);
    rd(1'b0, v); chk("R8 abort restarts count", v, 8'h66);

    // R9 clear of full on the frame-end edge
    send_ext(8'h88, 1'b1, 1'b0);
    rd(1'b0, v); chk("R9 new byte loaded", v, 8'h88);
    rd(1'b1, v); chk("R9 full kept no overrun", v, 8'h01);
    wr_stat(8'hFE);

    // R7 internal clock
    send_int(8'h5A);
    rd(1'b0, v); chk("R7 internal clock byte", v, 8'h5A);
    begin
      logic seen_low = 1'b0;
      repeat (12) begin @(negedge clk); if (!sck_o) seen_low = 1'b1; end
      chk("R8 sck_o high when disabled", {7'd0, seen_low}, 8'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule